// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Interrupts

This block is a small serial port on a simple register bus. Software writes bytes that leave on a transmit line, and reads bytes that arrive on a receive line. The line format is fixed: one low start bit, eight data bits with the least significant bit first, and one high stop bit. There is no parity and no flow control. Each direction holds one byte between the bus and its shift register. The bit period is a programmable number of clock cycles.

Status and interrupt flags report full buffers, transfers and overruns. Three interrupt lines leave the block: one for transmit, one for receive, and one shared by both overrun sources. Each source has its own enable bit. Software acknowledges a flag by writing a one to it.

The bus uses single-cycle read and write strobes on a byte address. Word index `bus_addr[4:2]` selects the register: 0 data, 1 status, 2 control, 3 interrupt flags, 4 divisor. Read data is combinational. The side effect of a data read happens on the clock edge while `bus_rd` is high.

Top module: `mmio_uart`

## Requirements
- R1: After reset, status, control and interrupt flags read 0, the divisor reads 16, `txd` is high and all three interrupt outputs are low.
- R2: The divisor register holds 21 bits, taken from `bus_wdata[20:0]`. A written value below 16 is stored as 16. The divisor sets the number of clock cycles in each bit period.
- R3: A transmitted frame is a low start bit, eight data bits least significant bit first, then a high stop bit. Each bit lasts one divisor period.
- R4: A data write while status bit 0 (transmit full) is clear stores the byte and sets status bit 0. When the shifter is idle and transmit is enabled (control bit 0), the byte moves into the shifter. This clears status bit 0 and sets interrupt flag bit 0.
- R5: A data write while status bit 0 is set drops the byte. It sets interrupt flag bit 2, and the flag is mirrored in status bit 2.
- R6: While control bit 0 is clear, a held byte stays in the buffer and `txd` stays high. Once the bit is set, the byte is sent.
- R7: With control bit 1 set, the receiver passes `rxd` through two flip-flops and starts on a falling edge. It samples each bit at mid-period. A good frame stores its byte, sets status bit 1 and sets interrupt flag bit 1. A data read returns the byte and clears status bit 1.
- R8: A frame that completes while status bit 1 is set is discarded. It sets interrupt flag bit 3, mirrored in status bit 3, and the stored byte is kept.
- R9: A frame whose stop bit samples low is discarded with no flag change. While control bit 1 is clear, incoming frames are ignored.
- R10: Writing interrupt flags clears each flag whose write bit is 1 and leaves the others. If a flag is set and cleared in the same cycle, the set wins.
- R11: `irq_tx` = flag0 & ctrl2. `irq_rx` = flag1 & ctrl3. `irq_ovr` = (flag2 & ctrl4) | (flag3 & ctrl5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_ovr | output | 1 | Shared overrun interrupt |

## Verification
A data write shows as status bit 0 one edge after the strobe. If the shifter is idle, the byte moves out on the following edge, which sets flag bit 0 and drives the start bit. Each bus task therefore returns at a falling clock edge after those registers have settled, and every register read samples at the next falling edge. A received byte lands about three cycles after the middle of its stop bit, which is still inside the frame time the bench drives. The bench waits out the whole frame before it reads status. A monitor decodes `txd` at the middle of each bit period, counted from the start edge, and compares each frame against a queue filled by the write task. A dropped byte or an early frame therefore shows up as a mismatch.

// File: rtl/mmio_uart.sv
module mmio_uart #(
  parameter int DIV_W   = 21,
  parameter int MIN_DIV = 16,
  parameter int BUS_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             rxd,
  output logic             txd,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_ovr
);
  localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(MIN_DIV);

  logic [2:0] idx;
  assign idx = bus_addr[4:2];
  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[BUS_W-1:DIV_W]};

  logic wr_data, wr_ctrl, wr_flag, wr_div, rd_data;
  assign wr_data = bus_wr && idx == 3'd0;
  assign wr_ctrl = bus_wr && idx == 3'd2;
  assign wr_flag = bus_wr && idx == 3'd3;
  assign wr_div  = bus_wr && idx == 3'd4;
  assign rd_data = bus_rd && idx == 3'd0;

  logic [5:0]       ctrl;
  logic [3:0]       flags;
  logic [DIV_W-1:0] div;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      div  <= DIV_FLOOR;
    end else begin
      if (wr_ctrl) ctrl <= bus_wdata[5:0];
      if (wr_div)  div  <= (bus_wdata[DIV_W-1:0] < DIV_FLOOR) ? DIV_FLOOR : bus_wdata[DIV_W-1:0];
    end

  // transmit path
  logic [7:0]       tx_hold;
  logic             tx_full, tx_busy, tx_load;
  logic [9:0]       tx_sh;
  logic [DIV_W-1:0] tx_cnt;
  logic [3:0]       tx_bit;

  assign tx_load = tx_full && !tx_busy && ctrl[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_hold <= '0;
      tx_full <= 1'b0;
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_bit  <= '0;
    end else begin
      if (wr_data && !tx_full) begin
        tx_hold <= bus_wdata[7:0];
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end
      if (tx_load) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, tx_hold, 1'b0};
        tx_cnt  <= '0;
        tx_bit  <= '0;
      end else if (tx_busy) begin
        if (tx_cnt >= div - 1'b1) begin
          tx_cnt <= '0;
          tx_sh  <= {1'b1, tx_sh[9:1]};
          if (tx_bit == 4'd9) tx_busy <= 1'b0;
          else tx_bit <= tx_bit + 1'b1;
        end else begin
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receive path
  logic             rx_s1, rx_s2, rx_prev, rx_act;
  logic [DIV_W-1:0] rx_cnt;
  logic [3:0]       rx_bit;
  logic [7:0]       rx_sh, rx_data;
  logic             rx_full, rx_done, rx_room;

  assign rx_done = rx_act && ctrl[1] && rx_cnt == '0 && rx_bit == 4'd9 && rx_s2;
  assign rx_room = !rx_full || rd_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_prev <= 1'b1;
      rx_act  <= 1'b0;
      rx_cnt  <= '0;
      rx_bit  <= '0;
      rx_sh   <= '0;
    end else begin
      rx_s1   <= rxd;
      rx_s2   <= rx_s1;
      rx_prev <= rx_s2;
      if (!rx_act) begin
        if (ctrl[1] && rx_prev && !rx_s2) begin
          rx_act <= 1'b1;
          rx_cnt <= (div >> 1) - 1'b1;
          rx_bit <= '0;
        end
      end else if (!ctrl[1]) begin
        rx_act <= 1'b0;
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - 1'b1;
      end else begin
        rx_cnt <= div - 1'b1;
        if (rx_bit == 4'd0) begin
          if (rx_s2) rx_act <= 1'b0;
          else rx_bit <= 4'd1;
        end else if (rx_bit == 4'd9) begin
          rx_act <= 1'b0;
        end else begin
          rx_sh  <= {rx_s2, rx_sh[7:1]};
          rx_bit <= rx_bit + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
    end else if (rx_done && rx_room) begin
      rx_data <= rx_sh;
      rx_full <= 1'b1;
    end else if (rd_data) begin
      rx_full <= 1'b0;
    end

  // interrupt flags
  logic [3:0] flag_set, flag_clr;
  assign flag_set = {rx_done && !rx_room, wr_data && tx_full, rx_done && rx_room, tx_load};
  assign flag_clr = wr_flag ? bus_wdata[3:0] : 4'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;

  assign irq_tx  = flags[0] & ctrl[2];
  assign irq_rx  = flags[1] & ctrl[3];
  assign irq_ovr = (flags[2] & ctrl[4]) | (flags[3] & ctrl[5]);

  always_comb
    case (idx)
      3'd0:    bus_rdata = BUS_W'(rx_data);
      3'd1:    bus_rdata = BUS_W'({flags[3], flags[2], rx_full, tx_full});
      3'd2:    bus_rdata = BUS_W'(ctrl);
      3'd3:    bus_rdata = BUS_W'(flags);
      3'd4:    bus_rdata = BUS_W'(div);
      default: bus_rdata = '0;
    endcase
endmodule

module mmio_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [3:0] wbits,
  input logic       txd,
  input logic       tx_full,
  input logic       tx_busy,
  input logic       tx_load,
  input logic       rx_full,
  input logic       rx_done,
  input logic [3:0] flags
);
  // R3
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(txd));
  // R5
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd0 && tx_full) |=> flags[2]);
  // R4
  tx_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (flags[0] && tx_busy && !tx_full));
  // R7
  rx_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[4:2] == 3'd0 && rx_full && !rx_done) |=> !rx_full);
  // R7
  rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> flags[1]);
  // R10
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[4:2] == 3'd3 && wbits[0] && !tx_load) |=> !flags[0]);
endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .wbits(bus_wdata[3:0]), .txd(txd), .tx_full(tx_full), .tx_busy(tx_busy),
  .tx_load(tx_load), .rx_full(rx_full), .rx_done(rx_done), .flags(flags)
);

// File: tb/tb_mmio_uart.sv
module tb_mmio_uart;
  localparam int DIV = 16;
  localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08, A_FLAG = 5'h0C, A_DIV = 5'h10;

  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, rxd = 1;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic txd, irq_tx, irq_rx, irq_ovr;
  int checks = 0, fails = 0;
  logic [7:0] tx_exp[$];

  always #10 clk = ~clk;

  mmio_uart dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_ovr(irq_ovr));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic br(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic put_tx(input logic [7:0] b);
    tx_exp.push_back(b);
    bw(A_DATA, {24'h0, b});
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk); rxd = 0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxd = stop;
    repeat (DIV) @(negedge clk);
    rxd = 1;
    repeat (6) @(negedge clk);
  endtask

  // scoreboard monitor for the transmit line
  initial begin
    logic [7:0] got;
    logic ok;
    forever begin
      @(negedge txd);
      ok = 1;
      repeat (DIV / 2) @(negedge clk);
      if (txd !== 1'b0) ok = 0;
      for (int i = 0; i < 8; i++) begin
        repeat (DIV) @(negedge clk);
        got[i] = txd;
      end
      repeat (DIV) @(negedge clk);
      if (txd !== 1'b1) ok = 0;
      chk(ok, "R3 frame start/stop", {31'h0, ok}, 32'h1);
      if (tx_exp.size() == 0) chk(0, "R3 unexpected frame", {24'h0, got}, 32'h0);
      else begin
        logic [7:0] e;
        e = tx_exp.pop_front();
        chk(got == e, "R3 frame data", {24'h0, got}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic quiet;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    br(A_STAT, rv); chk(rv == 0, "R1 status", rv, 0);
    br(A_CTRL, rv); chk(rv == 0, "R1 ctrl", rv, 0);
    br(A_FLAG, rv); chk(rv == 0, "R1 flags", rv, 0);
    br(A_DIV, rv);  chk(rv == 16, "R1 divisor", rv, 16);
    chk({txd, irq_tx, irq_rx, irq_ovr} == 4'b1000, "R1 lines", {28'h0, txd, irq_tx, irq_rx, irq_ovr}, 32'h8);
    // R2
    bw(A_DIV, 5); br(A_DIV, rv); chk(rv == 16, "R2 floor", rv, 16);
    bw(A_DIV, 32'hFFFF_FFFF); br(A_DIV, rv); chk(rv == 32'h1F_FFFF, "R2 width", rv, 32'h1F_FFFF);
    bw(A_DIV, DIV);
    // R4 / R5
    bw(A_CTRL, 32'h15);
    put_tx(8'hA5);
    br(A_STAT, rv); chk(rv[0] == 0, "R4 moved to shifter", rv, 0);
    br(A_FLAG, rv); chk(rv[0] == 1, "R4 tx flag", rv, 1);
    chk(irq_tx == 1, "R11 irq_tx", {31'h0, irq_tx}, 1);
    put_tx(8'h3C);
    br(A_STAT, rv); chk(rv[0] == 1, "R4 held full", rv, 1);
    bw(A_DATA, 32'h77);
    br(A_STAT, rv); chk(rv[2] == 1, "R5 status overrun", rv, 4);
    br(A_FLAG, rv); chk(rv[2] == 1, "R5 flag overrun", rv, 4);
    chk(irq_ovr == 1, "R11 irq_ovr tx", {31'h0, irq_ovr}, 1);
    wait (tx_exp.size() == 0);
    repeat (40) @(negedge clk);
    br(A_STAT, rv); chk(rv[0] == 0, "R4 empty after send", rv, 0);
    // R10
    bw(A_FLAG, 32'hF); br(A_FLAG, rv); chk(rv == 0, "R10 clear all", rv, 0);
    chk({irq_tx, irq_ovr} == 2'b00, "R11 irqs low", {30'h0, irq_tx, irq_ovr}, 0);
    // R6
    bw(A_CTRL, 0);
    bw(A_DATA, 32'hC3);
    quiet = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) quiet = 0;
    end
    chk(quiet, "R6 line idle while disabled", {31'h0, quiet}, 1);
    br(A_STAT, rv); chk(rv[0] == 1, "R6 byte held", rv, 1);
    tx_exp.push_back(8'hC3);
    bw(A_CTRL, 32'h01);
    repeat (3) @(negedge clk);
    br(A_FLAG, rv); chk(rv[0] == 1 && irq_tx == 0, "R11 irq_tx gated", {31'h0, irq_tx}, 0);
    bw(A_CTRL, 32'h05);
    chk(irq_tx == 1, "R11 irq_tx enabled", {31'h0, irq_tx}, 1);
    wait (tx_exp.size() == 0);
    repeat (20) @(negedge clk);
    // R7
    bw(A_FLAG, 32'hF);
    bw(A_CTRL, 32'h2A);
    send(8'h5A, 1);
    br(A_STAT, rv); chk(rv[1] == 1, "R7 rx full", rv, 2);
    br(A_FLAG, rv); chk(rv == 2, "R7 rx flag", rv, 2);
    chk(irq_rx == 1, "R11 irq_rx", {31'h0, irq_rx}, 1);
    br(A_DATA, rv); chk(rv == 32'h5A, "R7 data", rv, 32'h5A);
    br(A_STAT, rv); chk(rv[1] == 0, "R7 read clears full", rv, 0);
    // R8
    send(8'h11, 1);
    send(8'h22, 1);
    br(A_STAT, rv); chk(rv[3] == 1, "R8 status overrun", rv, 8);
    chk(irq_ovr == 1, "R11 irq_ovr rx", {31'h0, irq_ovr}, 1);
    bw(A_FLAG, 32'h8); br(A_FLAG, rv); chk(rv == 2, "R10 selective clear", rv, 2);
    br(A_DATA, rv); chk(rv == 32'h11, "R8 first byte kept", rv, 32'h11);
    // R9
    bw(A_FLAG, 32'hF);
    send(8'h33, 0);
    repeat (20) @(negedge clk);
    br(A_STAT, rv); chk(rv[1] == 0, "R9 bad stop rejected", rv, 0);
    br(A_FLAG, rv); chk(rv == 0, "R9 no flag", rv, 0);
    send(8'h44, 1);
    br(A_DATA, rv); chk(rv == 32'h44, "R9 recovers", rv, 32'h44);
    bw(A_CTRL, 0);
    send(8'h55, 1);
    br(A_STAT, rv); chk(rv[1] == 0, "R9 rx disabled", rv, 0);
    br(A_DATA, rv); chk(rv == 32'h44, "R9 data untouched", rv, 32'h44);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule